// File: doc/BRIEF.md
# PWM Clock-Divider Parameter Calculator

This block turns a requested PWM period, given as a count of source clock cycles, into settings for a two-stage clock divider and a 16-bit period counter. The first stage divides by a power of two, 2^m, with m between 0 and 8. The second stage divides by k+1, where k is an 8-bit prescaler. The block always picks the smallest m first and then the smallest k for that m, so that the divided period still fits the 65536-tick counter. It also returns the period count that the counter must be loaded with.

The block does not search over candidate settings. It makes one division by a fixed constant, 256 x 65537 = 16,777,472, and takes the find-last-set of that quotient as m. A second fixed division of the shifted count by 65537 gives k. A third division by k+1 gives the period count. All three divisions run one after another on a single restoring divider that produces one quotient bit per cycle.

A request is taken when `start` is high while `busy` is low. The four result outputs are loaded together and then hold their values. `done` pulses one cycle after the new values appear.

Top module: `pwm_div_calc`

## Requirements
- R1: The exponent output equals find-last-set(cycles / 16777472), where find-last-set gives the 1-based position of the highest set bit and 0 for 0. This holds whenever that value is at most 8.
- R2: With s = cycles >> m, the prescaler output equals s / 65537 (integer division). This is the smallest k for which s / (k+1) is at most 65536, and it is never larger than 255.
- R3: The period-count output equals s / (k+1), saturated at 65535.
- R4: Every result that is in range meets (cycles >> m) / (k+1) <= 65536, m <= 8 and k <= 255.
- R5: If find-last-set(cycles / 16777472) exceeds 8, the outputs are m = 8, k = 255, count = 65535, and the out-of-range flag is 1. For every other request the flag is 0.
- R6: The result outputs change only in the cycle just before `done`. `done` is a single-cycle pulse, and the outputs hold their values until the next result is loaded.
- R7: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until `done`. A `start` that arrives while `busy` is high is ignored and yields no result.
- R8: After reset, all result outputs, the flag, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, sampled while busy is low |
| cycles | input | 64 | Requested period in source clock cycles |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle pulse after the result is loaded |
| exp_m | output | 4 | Power-of-two divider exponent m |
| presc_k | output | 8 | Prescaler value k (divides by k+1) |
| ent_cnt | output | 16 | Period count after both divider stages |
| out_of_range | output | 1 | Request exceeds the largest divider setting |

## Verification
The assertions check on every cycle that m never exceeds 8 and that the out-of-range flag always comes with the saturated outputs. They also check that `done` and the divider's finish strobe are single pulses, that the outputs stay put outside the load cycle, and that the divider quotients for k and the period count stay inside their fields. The bench scenarios are needed for the values themselves. These cover the exact exponent and prescaler at the boundaries around 65536, 16,777,471 and 16,777,472, saturation of the count, the out-of-range edge at 4,295,032,832, and a start request that is dropped while a calculation is still running.

// File: rtl/pwm_div_calc_pkg.sv
`timescale 1ns/1ps
// Shared types for the PWM divider calculator.
// Assumes: a single sequencer walks these states in order; the GO states
// last exactly one cycle each.
package pwm_div_calc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_D1_GO   = 4'd1,
        ST_D1_WAIT = 4'd2,
        ST_EXP     = 4'd3,
        ST_D2_GO   = 4'd4,
        ST_D2_WAIT = 4'd5,
        ST_D3_GO   = 4'd6,
        ST_D3_WAIT = 4'd7,
        ST_LOAD    = 4'd8,
        ST_NOTE    = 4'd9
    } calc_state_t;

endpackage

// File: rtl/pwm_div_calc_rdiv.sv
`timescale 1ns/1ps
// Restoring divider: one quotient bit per cycle, DVD_W cycles per division.
// Assumes: divisor is nonzero at go; go is ignored while a division runs;
// quotient holds its value after fin until the next go.
module pwm_div_calc_rdiv #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quot,
    output logic             fin
);
    localparam int STEP_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0]  dvd_q;
    logic [DVS_W-1:0]  rem_q;
    logic [DVS_W-1:0]  dvs_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              fin_q;
    logic [DVS_W:0]    trial;
    logic [DVS_W:0]    diff;
    logic              fits;

    // Form the partial remainder for this step and compare it to the divisor.
    always_comb begin
        trial = {rem_q, dvd_q[DVD_W-1]};
        fits  = (trial >= {1'b0, dvs_q});
        diff  = trial - {1'b0, dvs_q};
    end

    // Shift one dividend bit in per cycle; the quotient bits fill the dividend register from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go && !run_q) begin
                dvd_q  <= dividend;
                rem_q  <= '0;
                dvs_q  <= divisor;
                step_q <= STEP_W'(DVD_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
                dvd_q  <= {dvd_q[DVD_W-2:0], fits};
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign quot = dvd_q;
    assign fin  = fin_q;

    // Divisors handed to this unit are never zero (R4 relies on it).
    assert_divisor_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (divisor != '0));

    // The finish strobe lasts one cycle (R6 timing relies on it).
    assert_fin_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q);

endmodule

// File: rtl/pwm_div_calc_fls.sv
`timescale 1ns/1ps
// Find-last-set: 1-based index of the highest set bit, 0 when the input is 0.
// Assumes: purely combinational; OUT_W is wide enough to hold W.
module pwm_div_calc_fls #(
    parameter int W     = 64,
    parameter int OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [OUT_W-1:0] pos
);
    // Scan from the bottom so that the highest set bit wins.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = OUT_W'(i + 1);
        end
    end
endmodule

// File: rtl/pwm_div_calc.sv
`timescale 1ns/1ps
// PWM divider parameter calculator (top).
// Picks the smallest exponent m, then the smallest prescaler k, such that
// (cycles >> m) / (k+1) fits a 2**CNT_W-tick counter, and returns the count.
// Assumes: one request at a time; start is ignored while busy; results hold
// until the next result is loaded; done follows the load by one cycle.
module pwm_div_calc
    import pwm_div_calc_pkg::*;
#(
    parameter int IN_W    = 64,
    parameter int CNT_W   = 16,
    parameter int PRE_W   = 8,
    parameter int EXP_MAX = 8,
    parameter int EXP_W   = 4,
    parameter int DVS_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IN_W-1:0]  cycles,
    output logic             busy,
    output logic             done,
    output logic [EXP_W-1:0] exp_m,
    output logic [PRE_W-1:0] presc_k,
    output logic [CNT_W-1:0] ent_cnt,
    output logic             out_of_range
);
    localparam int FLS_W = $clog2(IN_W + 1);
    localparam logic [DVS_W-1:0] SPAN_DIV = DVS_W'((2**CNT_W) + 1);
    localparam logic [DVS_W-1:0] STEP_DIV = DVS_W'(((2**CNT_W) + 1) * (2**PRE_W));
    localparam logic [IN_W-1:0]  CNT_CAP  = IN_W'((2**CNT_W) - 1);
    localparam logic [IN_W-1:0]  K_LIM    = IN_W'(2**PRE_W);
    localparam logic [IN_W-1:0]  Q_LIM    = IN_W'(2**CNT_W);
    localparam logic [FLS_W-1:0] EXP_LIM  = FLS_W'(EXP_MAX);
    localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(EXP_MAX);

    calc_state_t      state;
    logic [IN_W-1:0]  cyc_r;
    logic [IN_W-1:0]  shf_r;
    logic [EXP_W-1:0] m_w;
    logic [PRE_W-1:0] k_w;
    logic [CNT_W-1:0] e_w;
    logic             oor_w;
    logic             done_r;

    logic             div_go;
    logic [IN_W-1:0]  div_dvd;
    logic [DVS_W-1:0] div_dvs;
    logic [IN_W-1:0]  div_q;
    logic             div_fin;
    logic [FLS_W-1:0] fls_pos;

    // Choose the operands for whichever division the sequencer launches.
    always_comb begin
        div_go  = 1'b0;
        div_dvd = shf_r;
        div_dvs = SPAN_DIV;
        case (state)
            ST_D1_GO: begin
                div_go  = 1'b1;
                div_dvd = cyc_r;
                div_dvs = STEP_DIV;
            end
            ST_D2_GO: begin
                div_go  = 1'b1;
                div_dvd = shf_r;
                div_dvs = SPAN_DIV;
            end
            ST_D3_GO: begin
                div_go  = 1'b1;
                div_dvd = shf_r;
                div_dvs = DVS_W'(k_w) + DVS_W'(1);
            end
            default: ;
        endcase
    end

    pwm_div_calc_rdiv #(.DVD_W(IN_W), .DVS_W(DVS_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .quot     (div_q),
        .fin      (div_fin)
    );

    pwm_div_calc_fls #(.W(IN_W), .OUT_W(FLS_W)) u_fls (
        .vec (div_q),
        .pos (fls_pos)
    );

    // Sequence the three divisions and build the working result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cyc_r <= '0;
            shf_r <= '0;
            m_w   <= '0;
            k_w   <= '0;
            e_w   <= '0;
            oor_w <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cyc_r <= cycles;
                        state <= ST_D1_GO;
                    end
                end
                ST_D1_GO:   state <= ST_D1_WAIT;
                ST_D1_WAIT: if (div_fin) state <= ST_EXP;
                ST_EXP: begin
                    if (fls_pos > EXP_LIM) begin
                        m_w   <= EXP_TOP;
                        k_w   <= '1;
                        e_w   <= '1;
                        oor_w <= 1'b1;
                        state <= ST_LOAD;
                    end else begin
                        m_w   <= EXP_W'(fls_pos);
                        shf_r <= cyc_r >> fls_pos;
                        oor_w <= 1'b0;
                        state <= ST_D2_GO;
                    end
                end
                ST_D2_GO: state <= ST_D2_WAIT;
                ST_D2_WAIT: begin
                    if (div_fin) begin
                        k_w   <= div_q[PRE_W-1:0];
                        state <= ST_D3_GO;
                    end
                end
                ST_D3_GO: state <= ST_D3_WAIT;
                ST_D3_WAIT: begin
                    if (div_fin) begin
                        e_w   <= (div_q > CNT_CAP) ? '1 : div_q[CNT_W-1:0];
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: state <= ST_NOTE;
                ST_NOTE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Copy the working result to the outputs in one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_m        <= '0;
            presc_k      <= '0;
            ent_cnt      <= '0;
            out_of_range <= 1'b0;
        end else if (state == ST_LOAD) begin
            exp_m        <= m_w;
            presc_k      <= k_w;
            ent_cnt      <= e_w;
            out_of_range <= oor_w;
        end
    end

    // Raise done one cycle after the outputs were loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) done_r <= 1'b0;
        else        done_r <= (state == ST_NOTE);
    end

    assign done = done_r;
    assign busy = (state != ST_IDLE);

    // The exponent output never exceeds its limit.
    assert_exp_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exp_m <= EXP_TOP);

    // The prescaler quotient always fits its field.
    assert_presc_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_D2_WAIT && div_fin) |-> (div_q < K_LIM));

    // The raw period quotient never exceeds the counter span.
    assert_count_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_D3_WAIT && div_fin) |-> (div_q <= Q_LIM));

    // The out-of-range flag always comes with saturated settings.
    assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> (exp_m == EXP_TOP && presc_k == '1 && ent_cnt == '1));

    // done is a single pulse.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // The outputs only move on the load cycle.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |=> ($stable(exp_m) && $stable(presc_k) &&
                                $stable(ent_cnt) && $stable(out_of_range)));

    // An accepted start makes the block busy on the next cycle.
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: tb/sim_pwm_div_calc.sv
`timescale 1ns/1ps
module sim_pwm_div_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] cycles = '0;
    logic        busy, done, out_of_range;
    logic [3:0]  exp_m;
    logic [7:0]  presc_k;
    logic [15:0] ent_cnt;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        longint unsigned req;
        logic [3:0]  m;
        logic [7:0]  k;
        logic [15:0] e;
        logic        o;
    } res_t;

    res_t        pend[$];
    res_t        cur;
    logic [28:0] prev_s;
    bit          have_prev = 0;
    bit          mon_on = 0;

    always #10 clk = ~clk;

    pwm_div_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cycles(cycles),
        .busy(busy), .done(done), .exp_m(exp_m), .presc_k(presc_k),
        .ent_cnt(ent_cnt), .out_of_range(out_of_range)
    );

    task automatic chk(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference result computed from the requirements.
    function automatic res_t model(input longint unsigned c);
        res_t r;
        longint unsigned q, s, kk, e;
        int m;
        r.req = c;
        q = c / 64'd16777472;
        m = 0;
        while (m < 64 && (q >> m) != 0) m++;
        if (m > 8) begin
            r.m = 4'd8; r.k = 8'd255; r.e = 16'hFFFF; r.o = 1'b1;
        end else begin
            s  = c >> m;
            kk = s / 65537;
            e  = s / (kk + 1);
            r.m = 4'(m);
            r.k = kk[7:0];
            r.e = (e > 65535) ? 16'hFFFF : e[15:0];
            r.o = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [28:0] pack(input res_t r);
        return {r.m, r.k, r.e, r.o};
    endfunction

    // Per-clock comparison against the reference queue.
    always @(negedge clk) begin
        logic [28:0] smp;
        res_t x;
        longint unsigned s;
        if (rst_n && mon_on) begin
            smp = {exp_m, presc_k, ent_cnt, out_of_range};
            if (done) begin
                if (pend.size() == 0) begin
                    chk(1'b0, "R7 done without accepted request", 1, 0);
                end else begin
                    x = pend.pop_front();
                    chk(exp_m == x.m, "R1 exponent", exp_m, x.m);
                    chk(presc_k == x.k, "R2 prescaler", presc_k, x.k);
                    chk(ent_cnt == x.e, "R3 period count", ent_cnt, x.e);
                    chk(out_of_range == x.o, "R5 range flag", out_of_range, x.o);
                    if (!out_of_range) begin
                        s = (x.req >> exp_m) / (longint'(presc_k) + 1);
                        chk(s <= 65536 && exp_m <= 8, "R4 counter fit", s, 65536);
                    end
                    if (have_prev)
                        chk(prev_s == smp, "R6 outputs valid before done", prev_s, smp);
                    cur = x;
                end
            end else if (have_prev) begin
                chk(prev_s == pack(cur), "R6 outputs hold", prev_s, pack(cur));
            end
            if (start && !busy) pend.push_back(model(cycles));
            prev_s = smp;
            have_prev = 1;
        end
    end

    task automatic send(input logic [63:0] v);
        @(negedge clk);
        while (busy) @(negedge clk);
        @(posedge clk);
        #2 start = 1'b1; cycles = v;
        @(posedge clk);
        #2 start = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy || pend.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        longint unsigned x;
        cur = '{req: 0, m: 0, k: 0, e: 0, o: 0};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(exp_m == 0 && presc_k == 0 && ent_cnt == 0 && !out_of_range,
            "R8 reset outputs", {exp_m, presc_k, ent_cnt, out_of_range}, 0);
        chk(!busy && !done, "R8 reset handshake", {busy, done}, 0);
        mon_on = 1;

        // R1/R2/R3 boundaries around the counter span and the exponent steps
        send(64'd0);
        send(64'd1);
        send(64'd65535);
        send(64'd65536);          // R3 saturation at k=0
        send(64'd65537);
        send(64'd131073);
        send(64'd16777471);       // R2 largest k at m=0, R3 saturation
        send(64'd16777472);       // R1 first exponent step
        send(64'd33554943);
        send(64'd33554944);
        send(64'd1000000000);
        send(64'd4295032831);     // R1 largest in-range value, m=8
        send(64'd4295032832);     // R5 first out-of-range value
        send(64'hFFFF_FFFF_FFFF_FFFF);
        drain();

        // R7: a start while busy is dropped
        send(64'd24000000);
        repeat (5) @(posedge clk);
        #2 start = 1'b1; cycles = 64'd777;
        @(posedge clk);
        #2 start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R7 still busy with first request", busy, 1);
        drain();
        chk(pend.size() == 0 && ent_cnt == model(64'd24000000).e,
            "R7 ignored start left result", ent_cnt, model(64'd24000000).e);

        // Mixed patterns
        x = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 20; i++) begin
            x ^= x << 13; x ^= x >> 7; x ^= x << 17;
            send(x >> (20 + (i % 30)));
        end
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule